// File: doc/BRIEF.md
# Power-Fail Memory Write-Protect Supervisor

This block places a byte-wide memory array behind a supervisor that tracks the supply. Three digitized supply-monitor flags come in asynchronously. The first says the supply is above the full-operation level, the second that it is above the write-protect trip level, and the third that it is above the battery-switchover level. Each flag is synchronized and passed through a hysteresis filter. A small state machine then uses the filtered flags to decide whether the host may reach the array at all.

Below the trip level the block ignores the host bus, discards writes and floats its read data. When the supply also falls below the switchover level, the array is marked as running from backup. After power returns to the full-operation level, a hold-off interval must pass with the chip select idle before access reopens. A write that is in flight when protection engages is dropped.

Backup starts out disarmed (sealed). It becomes armed permanently the first time the supply clears the trip level. The array depth is set by `ADDR_W`; a full-size build uses 13 address bits for 8192 bytes. The default is smaller to keep elaboration light.

Top module: `pf_guard_sram`

## Requirements
- R1: After reset, `pf_state` is SEALED (3), `bk_armed` is 0, `on_backup` is 0 and `bus_rd_oe` is 0.
- R2: A change on a supply flag that lasts fewer than `FILT_CYC` cycles after synchronization leaves `pf_state` and `bk_armed` unchanged.
- R3: `bk_armed` goes to 1 the first time the filtered trip flag is high. It stays 1 through every later power-down until reset.
- R4: State codes are NORMAL=0, PROTECTED=1, BACKUP=2, SEALED=3 and RECOVERING=4. When armed and below the trip level, the state is PROTECTED if the switchover flag is high and BACKUP if it is low. `on_backup` is 1 only in BACKUP. While unarmed, the state stays SEALED with `on_backup` 0 whatever the switchover flag.
- R5: Above the trip level but below the full-operation level, the state is PROTECTED. With `TOL5`=1 the full-operation flag is `sup_full_i[1]` (tight level), and `sup_full_i[0]` is ignored. With `TOL5`=0 it is `sup_full_i[0]`.
- R6: On reaching the full-operation level from PROTECTED or BACKUP, the state becomes RECOVERING. It becomes NORMAL only after `REC_CYC` consecutive cycles with `bus_sel` low. Any cycle with `bus_sel` high restarts the count.
- R7: Outside NORMAL, host writes leave the array unchanged, and host reads leave `bus_rd_oe` at 0 and `bus_rdata` at 0.
- R8: In NORMAL, a cycle with `bus_sel`=1 and `bus_wr`=0 yields `bus_rd_oe`=1 in the next cycle, with `bus_rdata` equal to the stored byte at `bus_addr`.
- R9: In NORMAL, a write pulse (`bus_sel`=1 and `bus_wr`=1 held for one or more cycles) stores the address and data of its last cycle when the pulse ends.
- R10: If the state leaves NORMAL while a write pulse is held, that write is aborted and the addressed byte keeps its previous value.
- R11: Array contents survive a power-down through BACKUP and back to NORMAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_full_i | input | 2 | Above full-operation level: bit 1 is the tight level, bit 0 the loose level |
| sup_trip_i | input | 1 | Supply above write-protect trip level |
| sup_swo_i | input | 1 | Supply above battery-switchover level |
| bus_sel | input | 1 | Host chip select, active high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, 0 while floating |
| bus_rd_oe | output | 1 | Read data drive enable; 0 means high impedance |
| pf_state | output | 3 | Supervisor state code |
| bk_armed | output | 1 | Backup armed (seal broken) |
| on_backup | output | 1 | Array running from backup supply |

## Verification
The hardest case to reach from the ports is a write that is already under way when protection arrives. The filtered trip flag must fall while the host is still holding the write pulse. To force this, the bench raises select and write and keeps them high, then drops the raw trip flag. It continues to hold the pulse well past the synchronizer and filter delay, and only then releases it. The bench then brings the supply back, sits through the idle recovery window and reads the byte, which must still hold its old value. The recovery restart is reached in a similar way: a single select cycle is injected partway through RECOVERING, and the bench checks that NORMAL arrives late by the expected amount.

// File: rtl/pf_guard_sram.sv
module pf_guard_sram #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int FILT_CYC = 4,
  parameter int REC_CYC  = 32,
  parameter bit TOL5     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sup_full_i,
  input  logic              sup_trip_i,
  input  logic              sup_swo_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rd_oe,
  output logic [2:0]        pf_state,
  output logic              bk_armed,
  output logic              on_backup
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int FC_W  = $clog2(FILT_CYC + 1);
  localparam int RC_W  = $clog2(REC_CYC + 1);

  typedef enum logic [2:0] {
    S_NORMAL = 3'd0, S_PROT = 3'd1, S_BACKUP = 3'd2, S_SEALED = 3'd3, S_RECOVER = 3'd4
  } st_t;

  // flag order: 0 full, 1 trip, 2 switchover
  logic [2:0] raw, s1, s2, filt;
  logic [FC_W-1:0] fcnt [3];

  assign raw = {sup_swo_i, sup_trip_i, TOL5 ? sup_full_i[1] : sup_full_i[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      filt <= '0;
      for (int i = 0; i < 3; i++) fcnt[i] <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      for (int i = 0; i < 3; i++) begin
        if (s2[i] == filt[i]) fcnt[i] <= '0;
        else if (fcnt[i] == FC_W'(FILT_CYC - 1)) begin
          filt[i] <= s2[i];
          fcnt[i] <= '0;
        end else fcnt[i] <= fcnt[i] + 1'b1;
      end
    end
  end

  wire trip_ok = filt[1];
  wire full_ok = filt[0] & filt[1];
  wire swo_ok  = filt[2];

  st_t st, nxt;
  logic [RC_W-1:0] rcnt;
  logic armed;

  always_comb begin
    nxt = st;
    if (st == S_SEALED) begin
      if (trip_ok) nxt = S_PROT;
    end else if (!trip_ok) nxt = swo_ok ? S_PROT : S_BACKUP;
    else if (!full_ok) nxt = S_PROT;
    else if (st == S_PROT || st == S_BACKUP) nxt = S_RECOVER;
    else if (st == S_RECOVER && !bus_sel && rcnt == RC_W'(REC_CYC - 1)) nxt = S_NORMAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_SEALED;
      rcnt <= '0;
      armed <= 1'b0;
    end else begin
      st <= nxt;
      if (trip_ok) armed <= 1'b1;
      if (st != S_RECOVER || bus_sel) rcnt <= '0;
      else if (rcnt != RC_W'(REC_CYC - 1)) rcnt <= rcnt + 1'b1;
    end
  end

  assign pf_state  = st;
  assign bk_armed  = armed;
  assign on_backup = (st == S_BACKUP);

  wire is_norm = (st == S_NORMAL);
  wire wr_req  = bus_sel & bus_wr;
  wire rd_req  = bus_sel & ~bus_wr & is_norm;

  logic              wpend, oe_q;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic [DATA_W-1:0] mem [DEPTH];
  logic              mem_we;

  assign mem_we = wpend & ~wr_req & is_norm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpend <= 1'b0;
      wa_q  <= '0;
      wd_q  <= '0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= rd_req;
      if (!is_norm) wpend <= 1'b0;
      else if (wr_req) begin
        wpend <= 1'b1;
        wa_q  <= bus_addr;
        wd_q  <= bus_wdata;
      end else wpend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wa_q] <= wd_q;
    if (rd_req) rd_q <= mem[bus_addr];
  end

  assign bus_rd_oe = oe_q & is_norm;
  assign bus_rdata = bus_rd_oe ? rd_q : '0;

endmodule

// File: rtl/pf_guard_sram_chk.sv
module pf_guard_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic       bus_rd_oe,
  input logic [2:0] pf_state,
  input logic       bk_armed,
  input logic       on_backup,
  input logic       mem_we
);

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pf_state <= 3'd4); // R4

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bk_armed) |-> bk_armed); // R3

  AST_BACKUP_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    on_backup |-> (bk_armed && pf_state == 3'd2)); // R4

  AST_NORMAL_VIA_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_state == 3'd0 && $past(pf_state) != 3'd0) |-> ($past(pf_state) == 3'd4 && !$past(bus_sel))); // R6

  AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_oe |-> $past(bus_sel && !bus_wr)); // R8

  AST_WE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(bus_sel && bus_wr)); // R9

endmodule

bind pf_guard_sram pf_guard_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_rd_oe(bus_rd_oe), .pf_state(pf_state), .bk_armed(bk_armed),
  .on_backup(on_backup), .mem_we(mem_we)
);

// File: tb/pf_guard_sram_bench.sv
module pf_guard_sram_bench;
  localparam int AW = 10;
  localparam int FILT = 4;
  localparam int REC = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] sup_full = 2'b00;
  logic sup_trip = 1'b0, sup_swo = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic rd_oe, armed, on_bk;
  logic [2:0] st;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pf_guard_sram #(.ADDR_W(AW), .DATA_W(8), .FILT_CYC(FILT), .REC_CYC(REC), .TOL5(1'b1)) u_pf_guard_sram (
    .clk(clk), .rst_n(rst_n), .sup_full_i(sup_full), .sup_trip_i(sup_trip), .sup_swo_i(sup_swo),
    .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .bus_rd_oe(rd_oe), .pf_state(st), .bk_armed(armed), .on_backup(on_bk));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_sup(input logic [1:0] f, input logic t, input logic s, input int n);
    sup_full = f; sup_trip = t; sup_swo = s;
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(input logic [2:0] exp, input int limit);
    for (int i = 0; i < limit && st != exp; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, input int hold);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    repeat (hold) @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    d = rdata; oe = rd_oe;
    sel = 1'b0;
  endtask

  task automatic power_up();
    set_sup(2'b11, 1'b1, 1'b1, 1);
    wait_state(3'd0, 300);
  endtask

  task automatic t_reset();
    chk(st == 3'd3, "R1 state", st, 3);
    chk(armed == 1'b0, "R1 armed", armed, 0);
    chk(on_bk == 1'b0, "R1 on_backup", on_bk, 0);
    chk(rd_oe == 1'b0, "R1 oe", rd_oe, 0);
    set_sup(2'b00, 1'b0, 1'b1, 20);
    chk(st == 3'd3 && on_bk == 1'b0, "R4 unarmed swo-high sealed", st, 3);
    set_sup(2'b00, 1'b0, 1'b0, 20);
    chk(st == 3'd3 && on_bk == 1'b0, "R4 unarmed swo-low sealed", st, 3);
  endtask

  task automatic t_glitch();
    sup_swo = 1'b1;
    sup_trip = 1'b1;
    repeat (FILT - 1) @(negedge clk);
    sup_trip = 1'b0;
    repeat (20) @(negedge clk);
    chk(st == 3'd3, "R2 glitch state", st, 3);
    chk(armed == 1'b0, "R2 glitch armed", armed, 0);
  endtask

  task automatic t_first_up();
    logic [7:0] d; logic oe;
    set_sup(2'b01, 1'b1, 1'b1, 25);
    chk(st == 3'd1, "R5 loose flag only protected", st, 1);
    chk(armed == 1'b1, "R3 armed on first trip", armed, 1);
    set_sup(2'b11, 1'b1, 1'b1, 0);
    wait_state(3'd4, 40);
    chk(st == 3'd4, "R6 recovering entered", st, 4);
    repeat (REC / 2) @(negedge clk);
    do_read(10'd3, d, oe);
    chk(oe == 1'b0 && d == 8'd0, "R7 read in recovery", oe, 0);
    repeat (REC - 6) @(negedge clk);
    chk(st == 3'd4, "R6 select restarts recovery", st, 4);
    repeat (12) @(negedge clk);
    chk(st == 3'd0, "R6 normal after idle window", st, 0);
  endtask

  task automatic t_rw();
    logic [7:0] d; logic oe;
    do_write(10'd0, 8'h11, 1);
    do_write(10'h3FF, 8'hEE, 3);
    do_write(10'h155, 8'h5A, 2);
    do_write(10'd7, 8'hA5, 1);
    do_write(10'd9, 8'h42, 1);
    do_read(10'd0, d, oe);
    chk(oe && d == 8'h11, "R8 read addr 0", d, 8'h11);
    do_read(10'h3FF, d, oe);
    chk(oe && d == 8'hEE, "R9 long pulse write top addr", d, 8'hEE);
    do_read(10'h155, d, oe);
    chk(oe && d == 8'h5A, "R8 read mid addr", d, 8'h5A);
    do_write(10'h155, 8'hC3, 1);
    do_read(10'h155, d, oe);
    chk(oe && d == 8'hC3, "R9 overwrite", d, 8'hC3);
  endtask

  task automatic t_abort();
    logic [7:0] d; logic oe;
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = 10'd7; wdata = 8'h3C;
    set_sup(2'b00, 1'b0, 1'b1, 20);
    chk(st == 3'd1, "R10 protected during write", st, 1);
    sel = 1'b0; wr = 1'b0;
    repeat (3) @(negedge clk);
    power_up();
    do_read(10'd7, d, oe);
    chk(oe && d == 8'hA5, "R10 aborted write keeps old byte", d, 8'hA5);
  endtask

  task automatic t_protected();
    logic [7:0] d; logic oe;
    set_sup(2'b00, 1'b0, 1'b1, 20);
    chk(st == 3'd1 && on_bk == 1'b0, "R4 armed swo-high protected", st, 1);
    do_write(10'd9, 8'h99, 2);
    do_read(10'd9, d, oe);
    chk(oe == 1'b0 && d == 8'd0, "R7 read floats when protected", oe, 0);
    power_up();
    do_read(10'd9, d, oe);
    chk(oe && d == 8'h42, "R7 protected write discarded", d, 8'h42);
  endtask

  task automatic t_retention();
    logic [7:0] d; logic oe;
    set_sup(2'b00, 1'b0, 1'b1, 20);
    set_sup(2'b00, 1'b0, 1'b0, 20);
    chk(st == 3'd2, "R4 backup state", st, 2);
    chk(on_bk == 1'b1, "R4 on backup", on_bk, 1);
    chk(armed == 1'b1, "R3 arm survives power-down", armed, 1);
    set_sup(2'b00, 1'b0, 1'b1, 20);
    chk(st == 3'd1 && on_bk == 1'b0, "R4 back above switchover", st, 1);
    power_up();
    chk(st == 3'd0, "R6 normal again", st, 0);
    do_read(10'h3FF, d, oe);
    chk(oe && d == 8'hEE, "R11 top byte retained", d, 8'hEE);
    do_read(10'h155, d, oe);
    chk(oe && d == 8'hC3, "R11 mid byte retained", d, 8'hC3);
    do_read(10'd0, d, oe);
    chk(oe && d == 8'h11, "R11 low byte retained", d, 8'h11);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_glitch();
    t_first_up();
    t_rw();
    t_abort();
    t_protected();
    t_retention();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule